// File: doc/BRIEF.md
# Pairwise Pipeline Hazard Classifier

This block looks at every instruction currently held in a pipeline and sorts each ordered pair of them by data hazard. Each pipeline slot presents a valid flag. It also presents one destination register ID and two source register IDs, and a use flag for each of those three fields. Slot 0 holds the oldest instruction and higher indices hold younger ones. For every pair where slot i is older than slot j, the block reports three things separately. A read-after-write hazard means the older instruction writes a register that the younger one reads. A write-after-read hazard means the younger instruction writes a register that the older one reads. A write-after-write hazard means both instructions write the same register. A fourth flag is set when any of the three is present.

The comparisons themselves are combinational equality checks on register IDs. The four result matrices are registered, so a stall unit or issue logic downstream receives clean, flop-driven flags one clock after the slot contents were sampled. The number of slots and the register ID width are parameters. The defaults give five slots and 32 registers.

Top module: `hazard_pair_classifier`

## Requirements
- R1: All four result matrices are registered. They reflect the slot inputs sampled at the previous rising clock edge. A synchronous active-high reset clears every result bit to 0.
- R2: The read-after-write bit of pair (i,j) is 1 when older slot i has a live destination equal to a live source 1 or live source 2 ID of younger slot j.
- R3: The write-after-read bit of pair (i,j) is 1 when younger slot j has a live destination equal to a live source 1 or live source 2 ID of older slot i.
- R4: The write-after-write bit of pair (i,j) is 1 when both slots have live destinations with equal IDs.
- R5: The any-hazard bit of a pair is the OR of its three hazard bits.
- R6: Two slots that only share a source register, with no destination match, raise no hazard.
- R7: A register field takes part in a comparison only when its own use flag is 1. A field whose use flag is 0 never causes a match, even when its ID is equal.
- R8: A slot whose valid flag is 0 raises no hazard in any pair, whatever its fields hold.
- R9: Pair (i,j) sits at bit i*N+j of each matrix, where N is the slot count. Only pairs with i < j are evaluated. Every bit with i >= j is always 0, so the direction of a pair decides read-after-write versus write-after-read.
- R10: Every ordered pair of slots is compared, including slots that are not neighbours, such as the oldest and the youngest. Register IDs 0 and 31 compare like any other ID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| slot_valid | input | N | Slot holds an instruction, bit k for slot k |
| slot_dst_use | input | N | Destination field of slot k is written |
| slot_src1_use | input | N | Source 1 field of slot k is read |
| slot_src2_use | input | N | Source 2 field of slot k is read |
| slot_dst_id | input | N*ID_W | Destination register IDs, slot k at bits k*ID_W upward |
| slot_src1_id | input | N*ID_W | Source 1 register IDs, same packing |
| slot_src2_id | input | N*ID_W | Source 2 register IDs, same packing |
| raw_hz | output | N*N | Read-after-write matrix, pair (i,j) at bit i*N+j |
| war_hz | output | N*N | Write-after-read matrix, same indexing |
| waw_hz | output | N*N | Write-after-write matrix, same indexing |
| any_hz | output | N*N | Any hazard per pair, same indexing |

## Verification
Every result of this block is due exactly one rising edge after the slot inputs that produce it. No other delay exists, because there is a single register stage between the comparators and the ports. The bench changes the slot inputs on the falling edge and waits for one rising edge. It then reads the matrices on the following falling edge. In the latency test it also reads just before that rising edge, to confirm that the old results still hold. The reset checks assert reset while a hazard-producing pattern is applied, so the cleared outputs cannot be mistaken for an idle input.

// File: rtl/hzc_pkg.sv
package hzc_pkg;

  // Qualified use of one slot's register fields.
  typedef struct packed {
    logic dst_live;
    logic src1_live;
    logic src2_live;
  } slot_live_t;

  // Hazard classes for one ordered pair.
  typedef struct packed {
    logic raw;
    logic war;
    logic waw;
  } pair_hz_t;

endpackage

// File: rtl/hzc_slot_qual.sv
module hzc_slot_qual
  import hzc_pkg::*;
(
  input  logic       valid,
  input  logic       dst_use,
  input  logic       src1_use,
  input  logic       src2_use,
  output slot_live_t live
);

  // A field counts only if the slot is occupied and the field is in use.
  always_comb begin
    live.dst_live  = valid && dst_use;
    live.src1_live = valid && src1_use;
    live.src2_live = valid && src2_use;
  end

endmodule

// File: rtl/hzc_pair_cmp.sv
module hzc_pair_cmp
  import hzc_pkg::*;
#(
  parameter int ID_W = 5
) (
  input  slot_live_t      old_live,
  input  logic [ID_W-1:0] old_dst,
  input  logic [ID_W-1:0] old_src1,
  input  logic [ID_W-1:0] old_src2,
  input  slot_live_t      yng_live,
  input  logic [ID_W-1:0] yng_dst,
  input  logic [ID_W-1:0] yng_src1,
  input  logic [ID_W-1:0] yng_src2,
  output pair_hz_t        hz
);

  logic od_ys1, od_ys2, yd_os1, yd_os2, od_yd;

  always_comb begin
    od_ys1 = old_live.dst_live && yng_live.src1_live && (old_dst == yng_src1);
    od_ys2 = old_live.dst_live && yng_live.src2_live && (old_dst == yng_src2);
    yd_os1 = yng_live.dst_live && old_live.src1_live && (yng_dst == old_src1);
    yd_os2 = yng_live.dst_live && old_live.src2_live && (yng_dst == old_src2);
    od_yd  = old_live.dst_live && yng_live.dst_live && (old_dst == yng_dst);
    hz.raw = od_ys1 || od_ys2;
    hz.war = yd_os1 || yd_os2;
    hz.waw = od_yd;
  end

endmodule

// File: rtl/hazard_pair_classifier.sv
module hazard_pair_classifier
  import hzc_pkg::*;
#(
  parameter int N_SLOTS = 5,
  parameter int ID_W    = 5
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [N_SLOTS-1:0]        slot_valid,
  input  logic [N_SLOTS-1:0]        slot_dst_use,
  input  logic [N_SLOTS-1:0]        slot_src1_use,
  input  logic [N_SLOTS-1:0]        slot_src2_use,
  input  logic [N_SLOTS*ID_W-1:0]   slot_dst_id,
  input  logic [N_SLOTS*ID_W-1:0]   slot_src1_id,
  input  logic [N_SLOTS*ID_W-1:0]   slot_src2_id,
  output logic [N_SLOTS*N_SLOTS-1:0] raw_hz,
  output logic [N_SLOTS*N_SLOTS-1:0] war_hz,
  output logic [N_SLOTS*N_SLOTS-1:0] waw_hz,
  output logic [N_SLOTS*N_SLOTS-1:0] any_hz
);

  localparam int N_PAIRS = N_SLOTS * N_SLOTS;

  slot_live_t             live [N_SLOTS];
  logic [N_PAIRS-1:0]     raw_c, war_c, waw_c, any_c;

  for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
    hzc_slot_qual u_qual (
      .valid    (slot_valid[s]),
      .dst_use  (slot_dst_use[s]),
      .src1_use (slot_src1_use[s]),
      .src2_use (slot_src2_use[s]),
      .live     (live[s])
    );
  end

  for (genvar i = 0; i < N_SLOTS; i++) begin : g_old
    for (genvar j = 0; j < N_SLOTS; j++) begin : g_yng
      localparam int K = i * N_SLOTS + j;
      if (i < j) begin : g_pair
        pair_hz_t hz;
        hzc_pair_cmp #(.ID_W(ID_W)) u_cmp (
          .old_live (live[i]),
          .old_dst  (slot_dst_id [i*ID_W +: ID_W]),
          .old_src1 (slot_src1_id[i*ID_W +: ID_W]),
          .old_src2 (slot_src2_id[i*ID_W +: ID_W]),
          .yng_live (live[j]),
          .yng_dst  (slot_dst_id [j*ID_W +: ID_W]),
          .yng_src1 (slot_src1_id[j*ID_W +: ID_W]),
          .yng_src2 (slot_src2_id[j*ID_W +: ID_W]),
          .hz       (hz)
        );
        assign raw_c[K] = hz.raw;
        assign war_c[K] = hz.war;
        assign waw_c[K] = hz.waw;
        assign any_c[K] = hz.raw | hz.war | hz.waw;

        // R2: a read-after-write flag needs a live writer in the older slot
        a_r2_raw_needs_writer: assert property (@(posedge clk) disable iff (rst)
          raw_hz[K] |-> $past(slot_valid[i] && slot_dst_use[i] && slot_valid[j]));
        // R3: a write-after-read flag needs a live writer in the younger slot
        a_r3_war_needs_writer: assert property (@(posedge clk) disable iff (rst)
          war_hz[K] |-> $past(slot_valid[j] && slot_dst_use[j] && slot_valid[i]));
        // R4: write-after-write only on equal destination IDs
        a_r4_waw_same_dst: assert property (@(posedge clk) disable iff (rst)
          waw_hz[K] |-> $past(slot_dst_id[i*ID_W +: ID_W] == slot_dst_id[j*ID_W +: ID_W]));
        // R8: a pair with an empty slot stays quiet on the next cycle
        a_r8_invalid_quiet: assert property (@(posedge clk) disable iff (rst)
          !(slot_valid[i] && slot_valid[j]) |=> !any_hz[K]);
        // R5: combined flag agrees with the three class flags
        a_r5_any_matches: assert property (@(posedge clk) disable iff (rst)
          any_hz[K] == (raw_hz[K] || war_hz[K] || waw_hz[K]));
      end else begin : g_none
        assign raw_c[K] = 1'b0;
        assign war_c[K] = 1'b0;
        assign waw_c[K] = 1'b0;
        assign any_c[K] = 1'b0;

        // R9: bits with i >= j never raise
        a_r9_lower_zero: assert property (@(posedge clk) disable iff (rst)
          !(raw_hz[K] || war_hz[K] || waw_hz[K] || any_hz[K]));
      end
    end
  end

  // R1: one register stage, synchronous reset
  always_ff @(posedge clk) begin
    if (rst) begin
      raw_hz <= '0;
      war_hz <= '0;
      waw_hz <= '0;
      any_hz <= '0;
    end else begin
      raw_hz <= raw_c;
      war_hz <= war_c;
      waw_hz <= waw_c;
      any_hz <= any_c;
    end
  end

endmodule

// File: tb/sim_hazard_pair_classifier.sv
module sim_hazard_pair_classifier;

  localparam int N   = 5;
  localparam int W   = 5;
  localparam int SW  = 19;
  localparam int NP  = N * N;
  localparam int NV  = 9;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [N-1:0]      slot_valid = '0, slot_dst_use = '0, slot_src1_use = '0, slot_src2_use = '0;
  logic [N*W-1:0]    slot_dst_id = '0, slot_src1_id = '0, slot_src2_id = '0;
  logic [NP-1:0]     raw_hz, war_hz, waw_hz, any_hz;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  hazard_pair_classifier #(.N_SLOTS(N), .ID_W(W)) u0 (
    .clk, .rst, .slot_valid, .slot_dst_use, .slot_src1_use, .slot_src2_use,
    .slot_dst_id, .slot_src1_id, .slot_src2_id,
    .raw_hz, .war_hz, .waw_hz, .any_hz
  );

  // slot word: {valid, dst_use, src1_use, src2_use, dst[4:0], src1[4:0], src2[4:0]}
  function automatic logic [SW-1:0] sl(bit v, bit de, bit ae, bit be, int d, int a, int b);
    return {v, de, ae, be, 5'(d), 5'(a), 5'(b)};
  endfunction

  // bit of pair (older i, younger j) = i*N+j
  function automatic logic [NP-1:0] bp(int i, int j);
    return NP'(1) << (i * N + j);
  endfunction

  localparam logic [SW-1:0] IDLE = '0;

  // stimulus, slot 4 on the left, slot 0 on the right
  localparam logic [N*SW-1:0] STIM [NV] = '{
    {IDLE, IDLE, IDLE, sl(1,1,1,0,4,3,0), sl(1,1,1,1,3,2,1)},                     // 0 raw adjacent
    {IDLE, IDLE, sl(1,1,1,0,2,5,0), IDLE, sl(1,1,1,1,3,2,1)},                     // 1 war
    {IDLE, sl(1,1,1,1,3,2,5), IDLE, sl(1,1,1,0,2,3,0), sl(1,1,1,1,3,2,1)},        // 2 mixed three slots
    {IDLE, IDLE, IDLE, sl(1,1,1,0,5,1,0), sl(1,1,1,1,3,2,1)},                     // 3 shared source only
    {sl(1,1,0,1,4,7,9), IDLE, IDLE, IDLE, sl(1,0,1,1,7,4,6)},                     // 4 dst use off
    {IDLE, sl(1,1,1,0,12,6,6), IDLE, sl(1,1,1,0,6,3,12), IDLE},                   // 5 src use off
    {IDLE, IDLE, IDLE, sl(1,1,1,0,4,3,0), sl(0,1,1,1,3,2,1)},                     // 6 invalid slot
    {sl(1,1,1,1,0,31,31), IDLE, IDLE, IDLE, sl(1,1,1,1,31,0,0)},                  // 7 id extremes
    {IDLE, IDLE, IDLE, sl(1,1,1,1,3,2,1), sl(1,1,1,0,4,3,0)}                      // 8 reversed order
  };
  localparam logic [NP-1:0] ERAW [NV] = '{
    bp(0,1), '0, bp(0,1) | bp(1,3), '0, '0, bp(1,3), '0, bp(0,4), '0 };
  localparam logic [NP-1:0] EWAR [NV] = '{
    '0, bp(0,2), bp(0,1) | bp(1,3), '0, bp(0,4), '0, '0, bp(0,4), bp(0,1) };
  localparam logic [NP-1:0] EWAW [NV] = '{
    '0, '0, bp(0,3), '0, '0, '0, '0, '0, '0 };

  function automatic string vtag(int n);
    case (n)
      0: return "R2";
      1: return "R3";
      2: return "R4 R10";
      3: return "R6";
      4: return "R7";
      5: return "R7 R2";
      6: return "R8";
      7: return "R10";
      default: return "R9";
    endcase
  endfunction

  task automatic apply(input logic [N*SW-1:0] st);
    for (int k = 0; k < N; k++) begin
      logic [SW-1:0] w;
      w = st[k*SW +: SW];
      slot_valid[k]    = w[18];
      slot_dst_use[k]  = w[17];
      slot_src1_use[k] = w[16];
      slot_src2_use[k] = w[15];
      slot_dst_id [k*W +: W] = w[14:10];
      slot_src1_id[k*W +: W] = w[9:5];
      slot_src2_id[k*W +: W] = w[4:0];
    end
  endtask

  task automatic chk(input string req, input string what, input logic [NP-1:0] act, input logic [NP-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic chk_all(input string req, input logic [NP-1:0] er, input logic [NP-1:0] ea, input logic [NP-1:0] ew);
    chk(req, "raw", raw_hz, er);
    chk(req, "war", war_hz, ea);
    chk(req, "waw", waw_hz, ew);
    chk({req, " R5"}, "any", any_hz, er | ea | ew);
  endtask

  initial begin
    // R1: reset clears outputs even with a hazard pattern applied
    apply(STIM[2]);
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk_all("R1 reset", '0, '0, '0);

    // R1: first result one edge after reset release
    rst = 1'b0;
    apply(STIM[0]);
    @(posedge clk);
    @(negedge clk);
    chk_all("R1 release", ERAW[0], EWAR[0], EWAW[0]);

    // R1: new input not visible before the next rising edge
    apply(STIM[2]);
    #1;
    chk("R1 hold", "raw", raw_hz, ERAW[0]);
    @(posedge clk);
    @(negedge clk);
    chk_all("R1 update", ERAW[2], EWAR[2], EWAW[2]);

    // vector table
    for (int n = 0; n < NV; n++) begin
      apply(STIM[n]);
      @(posedge clk);
      @(negedge clk);
      chk_all(vtag(n), ERAW[n], EWAR[n], EWAW[n]);
    end

    // R8: all slots invalid but fields matching
    apply({N{sl(0,1,1,1,9,9,9)}});
    @(posedge clk);
    @(negedge clk);
    chk_all("R8 all invalid", '0, '0, '0);

    // R9 R10: every slot writes and reads r1, all pairs hazard upper only
    begin
      logic [NP-1:0] up;
      up = '0;
      for (int i = 0; i < N; i++)
        for (int j = i + 1; j < N; j++) up |= bp(i, j);
      apply({N{sl(1,1,1,0,1,1,0)}});
      @(posedge clk);
      @(negedge clk);
      chk_all("R9 R10 full", up, up, up);
    end

    // R1: reset in mid-run clears outputs
    apply(STIM[7]);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk_all("R1 midrun reset", '0, '0, '0);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk_all("R1 recover R10", ERAW[7], EWAR[7], EWAW[7]);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule